// File: doc/BRIEF.md
# Progressive ECC Protection-Level Manager

This block decides, page by page, how strong the BCH protection on a flash array must be, and it raises that strength while the array is in use. Every physical page starts at the weakest level. When a decode shows that the errors corrected came close to what the current level can correct, the page moves up one level. The extra check bits that a stronger level needs are not stored in the page. They are kept in a small on-chip store. A content-addressable table records which pages have been raised, the level each one has reached, and the slot in the store that holds its extra bits.

The BCH arithmetic sits outside the block, in one reconfigurable codec. The manager drives that codec through three handshaked requests: detect, correct and encode. Each request carries the level to use. A read runs in a fixed order: table lookup, fetch of the extra bits, then detection. Correction runs only when detection reports a nonzero syndrome. After that the manager decides on promotion, and a promotion re-encodes the page at its new level so that fresh extra bits can be stored. A write looks up the page's level, encodes the page at that level and stores the extra bits when the level is above the default. Every operation ends with a one-cycle completion pulse that carries the result.

Top module: `pecc_level_mgr`

## Requirements
- R1: During and straight after reset, `req_ready` is 1, `done` is 0 and no codec request is asserted. Every page reads back at level 0 until it is promoted.
- R2: `cdc_level` holds the level the current operation uses. That is 0 for a page with no table entry and the stored level for a page that has one, and it stays constant while a request waits for its acknowledge.
- R3: When a read request is accepted on clock edge A, `det_req` is low after edges A and A+1 and high after edge A+2. This covers one lookup cycle and one fetch cycle.
- R4: When detection returns `det_err`=0, `cor_req` is never asserted for that read, and `done_count` reports 0.
- R5: When detection returns `det_err`=1, `cor_req` follows. The count returned with `cor_ack` is reported on `done_count`.
- R6: Level L (0 to 3) can correct 4+4*L bits. After a read that neither failed nor hit the top level, the page is promoted when the count is at least the capacity minus 1. A promotion issues `enc_req` at level L+1, and `done_promoted`=1 with `done_level`=L+1.
- R7: A page at level 3 is never promoted, whatever the count.
- R8: `cor_fail`=1 gives `done_fail`=1, no promotion and no encode, and the page keeps its level.
- R9: When all 16 table entries are in use, a promotion of a page that has no entry sets `done_ovf`=1, performs no promotion and no encode, and leaves the page at level 0.
- R10: Promoting a page that already has an entry updates that entry's level in place. This works even when the table is full.
- R11: A write issues `enc_req` one cycle after acceptance, at the page's current level. When that level is above 0, the `enc_xbits` returned are stored. On later reads of the page they appear on `cdc_xbits`, which is all zeros for level-0 pages.
- R12: `done` is a single-cycle pulse. `req_ready` is low from the cycle after acceptance until `done`, and high again in the cycle after `done`.
- R13: At most one of `det_req`, `cor_req` and `enc_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_write | input | 1 | 1 = write (encode), 0 = read (decode) |
| req_page | input | 16 | Physical page number |
| req_ready | output | 1 | Manager idle, request taken when valid |
| cdc_level | output | 2 | Protection level for the codec |
| cdc_xbits | output | 156 | Stored extra check bits for decode |
| det_req | output | 1 | Detection request |
| det_ack | input | 1 | Detection finished |
| det_err | input | 1 | Nonzero syndrome found |
| cor_req | output | 1 | Correction request |
| cor_ack | input | 1 | Correction finished |
| cor_count | input | 5 | Number of bits corrected |
| cor_fail | input | 1 | Codeword uncorrectable |
| enc_req | output | 1 | Encode request |
| enc_ack | input | 1 | Encode finished |
| enc_xbits | input | 156 | Extra check bits from the encoder |
| done | output | 1 | Operation complete (pulse) |
| done_level | output | 2 | Page level after the operation |
| done_count | output | 5 | Corrected-bit count |
| done_fail | output | 1 | Uncorrectable read |
| done_promoted | output | 1 | Page was promoted |
| done_ovf | output | 1 | Promotion refused, table full |

## Verification
The assertions check the following every cycle:
- only one codec request is high at a time;
- the completion pulse lasts one cycle, and `req_ready` drops after acceptance;
- detection starts exactly three cycles after a read is accepted;
- correction only follows a detection that reported an error;
- the level stays constant during a handshake;
- a failed or refused promotion never reports a promotion.

The following can only be shown by the bench's scenarios, each compared against a behavioural model of page levels and stored bits:
- the promotion threshold at each level;
- the top-level cap;
- the in-place update of an existing entry while the table is full;
- the overflow refusal;
- the return of the correct extra bits on later reads.

// File: rtl/pecc_pkg.sv
package pecc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FETCH,
    S_DET,
    S_COR,
    S_CHK,
    S_ENC,
    S_DONE
  } pecc_state_e;

endpackage

// File: rtl/pecc_cam.sv
module pecc_cam #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  parameter int LVL_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [LVL_W-1:0] lk_lvl,
  output logic [IDX_W-1:0] free_idx,
  output logic             full,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [LVL_W-1:0] wr_lvl
);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [LVL_W-1:0]   lvl_q [ENTRIES];

  // per-entry key compare and storage
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (key_q[g] == lk_key);

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        key_q[g] <= wr_key;
        lvl_q[g] <= wr_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // hit encoder, lowest matching index
  always_comb begin
    lk_hit = |match;
    lk_idx = '0;
    lk_lvl = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_idx = IDX_W'(i);
        lk_lvl = lvl_q[i];
      end
    end
  end

  // lowest free entry for allocation
  always_comb begin
    full     = &vld_q;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pecc_xram.sv
module pecc_xram #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 156,
  localparam int ADR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/pecc_seq.sv
module pecc_seq
  import pecc_pkg::*;
#(
  parameter int PAGE_W      = 16,
  parameter int ENTRIES     = 16,
  parameter int LEVELS      = 4,
  parameter int T_BASE      = 4,
  parameter int T_STEP      = 4,
  parameter int PROMO_SLACK = 1,
  parameter int XB_W        = 156,
  localparam int LVL_W      = $clog2(LEVELS),
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int CNT_W      = $clog2(T_BASE + T_STEP * (LEVELS - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  // table
  output logic [PAGE_W-1:0] lk_key,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [LVL_W-1:0]  lk_lvl,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic              full,
  output logic              cw_en,
  output logic [IDX_W-1:0]  cw_idx,
  output logic [PAGE_W-1:0] cw_key,
  output logic [LVL_W-1:0]  cw_lvl,
  // extra-bit store
  output logic              xr_rd_en,
  output logic [IDX_W-1:0]  xr_rd_addr,
  input  logic [XB_W-1:0]   xr_rd_data,
  output logic              xr_wr_en,
  output logic [IDX_W-1:0]  xr_wr_addr,
  // codec
  output logic [LVL_W-1:0]  cdc_level,
  output logic [XB_W-1:0]   cdc_xbits,
  output logic              det_req,
  input  logic              det_ack,
  input  logic              det_err,
  output logic              cor_req,
  input  logic              cor_ack,
  input  logic [CNT_W-1:0]  cor_count,
  input  logic              cor_fail,
  output logic              enc_req,
  input  logic              enc_ack,
  // result
  output logic              done,
  output logic [LVL_W-1:0]  done_level,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_fail,
  output logic              done_promoted,
  output logic              done_ovf
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  pecc_state_e       st_q, st_d;
  logic [PAGE_W-1:0] page_q;
  logic              wr_q;
  logic              hit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q, prom_q, ovf_q;

  // clock enables
  logic en_take, en_look, en_cor, en_chk;
  // promotion decision
  int               cap;
  logic             want, do_prom, ovf_d;
  logic [IDX_W-1:0] tgt_idx;

  assign en_take = (st_q == S_IDLE) && req_valid;
  assign en_look = (st_q == S_LOOK);
  assign en_cor  = (st_q == S_COR) && cor_ack;
  assign en_chk  = (st_q == S_CHK);

  always_comb begin
    cap     = T_BASE + T_STEP * int'(lvl_q);
    want    = !fail_q && (int'(cnt_q) + PROMO_SLACK >= cap) && (lvl_q != TOP_LVL);
    do_prom = want && (hit_q || !full);
    ovf_d   = want && !hit_q && full;
    tgt_idx = hit_q ? idx_q : free_idx;
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (req_valid) st_d = S_LOOK;
      S_LOOK:  st_d = wr_q ? S_ENC : S_FETCH;
      S_FETCH: st_d = S_DET;
      S_DET:   if (det_ack) st_d = det_err ? S_COR : S_CHK;
      S_COR:   if (cor_ack) st_d = S_CHK;
      S_CHK:   st_d = do_prom ? S_ENC : S_DONE;
      S_ENC:   if (enc_ack) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      prom_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (en_take) begin
        cnt_q  <= '0;
        fail_q <= 1'b0;
        prom_q <= 1'b0;
        ovf_q  <= 1'b0;
      end
      if (en_cor) begin
        cnt_q  <= cor_count;
        fail_q <= cor_fail;
      end
      if (en_chk) begin
        prom_q <= do_prom;
        ovf_q  <= ovf_d;
      end
    end
  end

  // operand registers, no reset
  always_ff @(posedge clk) begin
    if (en_take) begin
      page_q <= req_page;
      wr_q   <= req_write;
    end
    if (en_look) begin
      hit_q <= lk_hit;
      idx_q <= lk_idx;
      lvl_q <= lk_hit ? lk_lvl : '0;
    end
    if (en_chk && do_prom) begin
      hit_q <= 1'b1;
      idx_q <= tgt_idx;
      lvl_q <= lvl_q + 1'b1;
    end
  end

  assign lk_key = page_q;
  assign cw_en  = en_chk && do_prom;
  assign cw_idx = tgt_idx;
  assign cw_key = page_q;
  assign cw_lvl = lvl_q + 1'b1;

  assign xr_rd_en   = (st_q == S_FETCH);
  assign xr_rd_addr = idx_q;
  assign xr_wr_en   = (st_q == S_ENC) && enc_ack && (lvl_q != '0);
  assign xr_wr_addr = idx_q;

  assign req_ready = (st_q == S_IDLE);
  assign det_req   = (st_q == S_DET);
  assign cor_req   = (st_q == S_COR);
  assign enc_req   = (st_q == S_ENC);
  assign cdc_level = lvl_q;
  assign cdc_xbits = hit_q ? xr_rd_data : '0;

  assign done          = (st_q == S_DONE);
  assign done_level    = lvl_q;
  assign done_count    = cnt_q;
  assign done_fail     = fail_q;
  assign done_promoted = prom_q;
  assign done_ovf      = ovf_q;

endmodule

// File: rtl/pecc_level_mgr.sv
module pecc_level_mgr #(
  parameter int PAGE_W      = 16,
  parameter int ENTRIES     = 16,
  parameter int LEVELS      = 4,
  parameter int T_BASE      = 4,
  parameter int T_STEP      = 4,
  parameter int SYM_W       = 13,
  parameter int PROMO_SLACK = 1,
  localparam int LVL_W      = $clog2(LEVELS),
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int CNT_W      = $clog2(T_BASE + T_STEP * (LEVELS - 1) + 1),
  localparam int XB_W       = SYM_W * T_STEP * (LEVELS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  output logic [LVL_W-1:0]  cdc_level,
  output logic [XB_W-1:0]   cdc_xbits,
  output logic              det_req,
  input  logic              det_ack,
  input  logic              det_err,
  output logic              cor_req,
  input  logic              cor_ack,
  input  logic [CNT_W-1:0]  cor_count,
  input  logic              cor_fail,
  output logic              enc_req,
  input  logic              enc_ack,
  input  logic [XB_W-1:0]   enc_xbits,
  output logic              done,
  output logic [LVL_W-1:0]  done_level,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_fail,
  output logic              done_promoted,
  output logic              done_ovf
);

  logic [PAGE_W-1:0] lk_key;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [LVL_W-1:0]  lk_lvl;
  logic [IDX_W-1:0]  free_idx;
  logic              full;
  logic              cw_en;
  logic [IDX_W-1:0]  cw_idx;
  logic [PAGE_W-1:0] cw_key;
  logic [LVL_W-1:0]  cw_lvl;
  logic              xr_rd_en, xr_wr_en;
  logic [IDX_W-1:0]  xr_rd_addr, xr_wr_addr;
  logic [XB_W-1:0]   xr_rd_data;

  pecc_cam #(
    .ENTRIES(ENTRIES), .KEY_W(PAGE_W), .LVL_W(LVL_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n),
    .lk_key(lk_key), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_lvl(lk_lvl),
    .free_idx(free_idx), .full(full),
    .wr_en(cw_en), .wr_idx(cw_idx), .wr_key(cw_key), .wr_lvl(cw_lvl)
  );

  pecc_xram #(
    .DEPTH(ENTRIES), .WIDTH(XB_W)
  ) u_xram (
    .clk(clk),
    .wr_en(xr_wr_en), .wr_addr(xr_wr_addr), .wr_data(enc_xbits),
    .rd_en(xr_rd_en), .rd_addr(xr_rd_addr), .rd_data(xr_rd_data)
  );

  pecc_seq #(
    .PAGE_W(PAGE_W), .ENTRIES(ENTRIES), .LEVELS(LEVELS), .T_BASE(T_BASE),
    .T_STEP(T_STEP), .PROMO_SLACK(PROMO_SLACK), .XB_W(XB_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_page(req_page),
    .req_ready(req_ready),
    .lk_key(lk_key), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_lvl(lk_lvl),
    .free_idx(free_idx), .full(full),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_key(cw_key), .cw_lvl(cw_lvl),
    .xr_rd_en(xr_rd_en), .xr_rd_addr(xr_rd_addr), .xr_rd_data(xr_rd_data),
    .xr_wr_en(xr_wr_en), .xr_wr_addr(xr_wr_addr),
    .cdc_level(cdc_level), .cdc_xbits(cdc_xbits),
    .det_req(det_req), .det_ack(det_ack), .det_err(det_err),
    .cor_req(cor_req), .cor_ack(cor_ack), .cor_count(cor_count), .cor_fail(cor_fail),
    .enc_req(enc_req), .enc_ack(enc_ack),
    .done(done), .done_level(done_level), .done_count(done_count),
    .done_fail(done_fail), .done_promoted(done_promoted), .done_ovf(done_ovf)
  );

endmodule

// File: rtl/pecc_level_mgr_chk.sv
module pecc_level_mgr_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LVL_W-1:0] cdc_level,
  input logic             det_req,
  input logic             det_ack,
  input logic             det_err,
  input logic             cor_req,
  input logic             enc_req,
  input logic             done,
  input logic [LVL_W-1:0] done_level,
  input logic             done_fail,
  input logic             done_promoted,
  input logic             done_ovf
);

  AST_ONE_CODEC_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({det_req, cor_req, enc_req}) <= 1); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R12

  AST_DET_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_req) |-> $past(req_valid && req_ready, 3)); // R3

  AST_COR_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cor_req) |-> $past(det_ack && det_err)); // R5

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (det_req && !det_ack) |=> $stable(cdc_level)); // R2

  AST_PROMO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_promoted) |-> (done_level != '0)); // R6

  AST_FAIL_NO_PROMO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> !done_promoted); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_ovf) |-> (!done_promoted && done_level == '0)); // R9

endmodule

bind pecc_level_mgr pecc_level_mgr_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_pecc_level_mgr.sv
module sim_pecc_level_mgr;

  localparam int PW = 16;
  localparam int LW = 2;
  localparam int CW = 5;
  localparam int XW = 156;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_write;
  logic [PW-1:0] req_page;
  logic          req_ready;
  logic [LW-1:0] cdc_level;
  logic [XW-1:0] cdc_xbits;
  logic          det_req, det_ack, det_err;
  logic          cor_req, cor_ack, cor_fail;
  logic [CW-1:0] cor_count;
  logic          enc_req, enc_ack;
  logic [XW-1:0] enc_xbits;
  logic          done, done_fail, done_promoted, done_ovf;
  logic [LW-1:0] done_level;
  logic [CW-1:0] done_count;

  pecc_level_mgr u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model: page -> level, page -> stored extra bits
  int            m_lvl [int];
  logic [XW-1:0] m_xb  [int];
  int            m_ent = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_x(input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R11 xbits: actual %h expected %h", act, exp);
    end
  endtask

  function automatic logic [XW-1:0] rnd_x();
    logic [XW-1:0] v;
    for (int k = 0; k < XW; k++) v[k] = 1'($urandom);
    return v;
  endfunction

  function automatic logic sel(input int w);
    case (w)
      0: return det_req;
      1: return cor_req;
      2: return enc_req;
      default: return done;
    endcase
  endfunction

  task automatic await(input int w, input string req);
    int n = 0;
    while (!sel(w) && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(sel(w) === 1'b1, req, "handshake", longint'(sel(w)), 1);
  endtask

  // per-clock checks against the model's rules
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk($countones({det_req, cor_req, enc_req}) <= 1, "R13", "codec reqs",
          $countones({det_req, cor_req, enc_req}), 1);
    end
  end

  task automatic finish_check(input int exp_lvl, input int exp_cnt, input bit exp_fail,
                              input bit exp_prom, input bit exp_ovf, input string tag);
    chk(done_level == LW'(exp_lvl), tag, "done_level", done_level, exp_lvl);
    chk(done_count == CW'(exp_cnt), tag, "done_count", done_count, exp_cnt);
    chk(done_fail == exp_fail, tag, "done_fail", done_fail, exp_fail);
    chk(done_promoted == exp_prom, tag, "done_promoted", done_promoted, exp_prom);
    chk(done_ovf == exp_ovf, tag, "done_ovf", done_ovf, exp_ovf);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R12", "pulse end / ready", {done, req_ready}, 1);
  endtask

  task automatic do_read(input int page, input bit err, input int count, input bit fail);
    int lvl, cap, exp_lvl;
    bit has, want, prom, ovf, stray;
    logic [XW-1:0] v;
    string tag;
    has  = m_lvl.exists(page);
    lvl  = has ? m_lvl[page] : 0;
    cap  = 4 + 4 * lvl;
    want = err && !fail && (count + 1 >= cap) && (lvl < 3);
    prom = want && (has || m_ent < 16);
    ovf  = want && !prom;
    exp_lvl = prom ? lvl + 1 : lvl;
    if (prom && has) tag = "R10";
    else if (prom) tag = "R6";
    else if (ovf) tag = "R9";
    else if (err && fail) tag = "R8";
    else if (lvl == 3) tag = "R7";
    else if (!err) tag = "R4";
    else tag = "R5";

    req_valid = 1'b1; req_write = 1'b0; req_page = PW'(page);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", "ready after take", req_ready, 0);
    chk(det_req == 1'b0, "R3", "det_req after A", det_req, 0);
    @(negedge clk);
    chk(det_req == 1'b0, "R3", "det_req after A+1", det_req, 0);
    @(negedge clk);
    chk(det_req == 1'b1, "R3", "det_req after A+2", det_req, 1);
    chk(cdc_level == LW'(lvl), "R2", "detect level", cdc_level, lvl);
    chk_x(cdc_xbits, lvl > 0 ? m_xb[page] : '0);
    @(negedge clk);
    det_ack = 1'b1; det_err = err;
    @(negedge clk);
    det_ack = 1'b0; det_err = 1'b0;
    if (err) begin
      await(1, "R5");
      chk(cdc_level == LW'(lvl), "R2", "correct level", cdc_level, lvl);
      cor_ack = 1'b1; cor_count = CW'(count); cor_fail = fail;
      @(negedge clk);
      cor_ack = 1'b0; cor_count = '0; cor_fail = 1'b0;
    end
    if (prom) begin
      await(2, tag);
      chk(cdc_level == LW'(lvl + 1), tag, "promote encode level", cdc_level, lvl + 1);
      v = rnd_x();
      enc_ack = 1'b1; enc_xbits = v;
      @(negedge clk);
      enc_ack = 1'b0;
      if (!has) m_ent++;
      m_lvl[page] = lvl + 1;
      m_xb[page]  = v;
    end
    stray = 1'b0;
    for (int n = 0; n < 100 && !done; n++) begin
      if (cor_req || enc_req) stray = 1'b1;
      @(negedge clk);
    end
    chk(!stray, tag, "no unexpected correct/encode", stray, 0);
    chk(done == 1'b1, tag, "done seen", done, 1);
    finish_check(exp_lvl, err ? count : 0, err && fail, prom, ovf, tag);
  endtask

  task automatic do_write(input int page);
    int lvl;
    logic [XW-1:0] v;
    lvl = m_lvl.exists(page) ? m_lvl[page] : 0;
    req_valid = 1'b1; req_write = 1'b1; req_page = PW'(page);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(enc_req == 1'b0, "R11", "enc_req after A", enc_req, 0);
    @(negedge clk);
    chk(enc_req == 1'b1, "R11", "enc_req after A+1", enc_req, 1);
    chk(cdc_level == LW'(lvl), "R2", "write level", cdc_level, lvl);
    v = rnd_x();
    enc_ack = 1'b1; enc_xbits = v;
    @(negedge clk);
    enc_ack = 1'b0;
    if (lvl > 0) m_xb[page] = v;
    await(3, "R11");
    finish_check(lvl, 0, 1'b0, 1'b0, 1'b0, "R11");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_page = '0;
    det_ack = 1'b0; det_err = 1'b0;
    cor_ack = 1'b0; cor_count = '0; cor_fail = 1'b0;
    enc_ack = 1'b0; enc_xbits = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "reset ready/done", {req_ready, done}, 2);
    chk({det_req, cor_req, enc_req} == 3'b000, "R1", "reset reqs", {det_req, cor_req, enc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "after reset", {req_ready, done}, 2);

    // main page through all levels
    do_write(16'h0100);            // R11 level 0, nothing stored
    do_read(16'h0100, 0, 0, 0);    // R4
    do_read(16'h0100, 1, 2, 0);    // R5 slack 2
    do_read(16'h0100, 1, 3, 0);    // R6 -> 1
    do_read(16'h0100, 0, 0, 0);    // R11 bits back
    do_read(16'h0100, 1, 7, 0);    // R10 -> 2
    do_read(16'h0100, 1, 11, 0);   // R10 -> 3
    do_read(16'h0100, 1, 16, 0);   // R7 stays 3
    do_write(16'h0100);            // R11 new bits at level 3
    do_read(16'h0100, 0, 0, 0);

    // failure leaves level alone
    do_read(16'h0150, 1, 4, 1);    // R8
    do_read(16'h0150, 0, 0, 0);

    // fill remaining 15 entries
    for (int i = 0; i < 15; i++) do_read(16'h0200 + i, 1, 4, 0);
    do_read(16'h0300, 1, 3, 0);    // R9 overflow
    do_read(16'h0300, 0, 0, 0);    // still level 0
    do_read(16'h0200, 1, 7, 0);    // R10 in place while full
    do_read(16'h020E, 0, 0, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule